// File: doc/BRIEF.md
# Sequential binary to balanced-ternary converter

This block takes a signed two's-complement integer and rewrites it as a fixed-width word of balanced-ternary digits. Each digit is minus one, zero or plus one, and each is held as a two-bit code. Negative numbers need no separate sign digit. The sign of the value is the sign of its leading nonzero digit. Negating a value swaps every plus-one digit for a minus-one digit and every minus-one digit for a plus-one digit.

A conversion starts with a one-cycle start strobe while the block is idle. The block then produces one digit per clock, least significant digit first. In each step the running value is divided by three. A remainder of zero or one is used as the digit. A remainder of two becomes a minus-one digit, and one is added to the quotient. When the last digit has been written, a one-cycle done pulse is raised.

Some values have a magnitude larger than the digit word can hold. For these, an overflow flag is set and every digit is forced to zero. The conversion keeps its normal latency in that case.

Top module: `bt_converter`

## Requirements
- R1: Digit codes are 2'b00 for zero, 2'b01 for plus one and 2'b10 for minus one. The code 2'b11 never appears on `digits`.
- R2: The digit with weight 3^i sits at `digits[2i+1:2i]`, so the most significant digit is in the top bits. For every input in range, the sum of digit times 3^i equals the input.
- R3: When `start` is high while `busy` is low, the input is captured at that clock edge and `busy` is high in the next cycle.
- R4: `done` is high for exactly one cycle, NDIG cycles after the accepting edge. In that cycle the final digit is already visible and `busy` is low.
- R5: A `start` strobe while `busy` is high is ignored. The running conversion and its result are unchanged.
- R6: An input with magnitude above (3^NDIG-1)/2 (3280 for 8 digits) sets `overflow` and leaves all digits zero. Inputs of exactly +3280 and -3280 convert without overflow.
- R7: `overflow` and `digits` hold their values until the next accepted start. Each accepted start clears all digits and reloads the flag.
- R8: The result for -x equals the result for x with every 2'b01 digit swapped with 2'b10.
- R9: After reset, `busy`, `done` and `overflow` are low and `digits` is all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a conversion; acted on only while idle |
| din | input | IN_W | Signed two's-complement input value |
| busy | output | 1 | Conversion in progress |
| done | output | 1 | One-cycle pulse when the digit word is complete |
| overflow | output | 1 | Last captured input did not fit the digit word |
| digits | output | 2*NDIG | Balanced-ternary digits, most significant in the top bits |

## Verification
Some properties are checked by assertions on every cycle:
- The reserved code never appears on `digits`.
- `done` lasts one cycle and never coincides with `busy`.
- An accepted start always leads to a busy cycle.
- A strobe during a conversion never cuts it short.
- An overflowed result always reads as zero.

The numerical correctness of the digits can only be shown by the bench's scenarios, because it depends on particular inputs. The same holds for the negation symmetry, the exact ±3280 range edges, and the fact that an ignored strobe leaves the result of the running conversion intact.

// File: rtl/bt_pkg.sv
package bt_pkg;
   typedef enum logic [1:0] {
      BT_ZERO = 2'b00,
      BT_POS  = 2'b01,
      BT_NEG  = 2'b10
   } bt_digit_e;

   // Largest magnitude representable with n balanced digits: (3^n - 1) / 2
   function automatic longint bt_limit(input int n);
      longint p;
      p = 1;
      for (int i = 0; i < n; i++) p = p * 3;
      return (p - 1) / 2;
   endfunction

   function automatic int bt_bits_for(input longint lim);
      int b;
      b = 0;
      while ((longint'(1) << b) <= lim) b++;
      return b;
   endfunction
endpackage

// File: rtl/bt_range_check.sv
module bt_range_check #(
   parameter int     IN_W = 16,
   parameter int     VW   = 14,
   parameter longint LIM  = 3280
) (
   input  logic [IN_W-1:0]        din,
   output logic                   over,
   output logic signed [VW-1:0]   start_val
);
   longint sx;

   always_comb begin
      sx        = longint'($signed(din));
      over      = (sx > LIM) || (sx < -LIM);
      start_val = over ? '0 : $signed(sx[VW-1:0]);
   end
endmodule

// File: rtl/bt_digit_step.sv
module bt_digit_step
   import bt_pkg::*;
#(
   parameter int VW = 14
) (
   input  logic signed [VW-1:0] v,
   output bt_digit_e            code,
   output logic signed [VW-1:0] v_next
);
   localparam logic signed [VW-1:0] THREE = VW'(3);
   localparam logic signed [VW-1:0] TWO   = VW'(2);
   localparam logic signed [VW-1:0] ONE   = VW'(1);

   logic signed [VW-1:0] rem;
   logic signed [VW-1:0] quo;

   always_comb begin
      rem = v % THREE;
      if (rem < 0) rem = rem + THREE;
      quo = (v - rem) / THREE;
      if (rem == TWO) begin
         code   = BT_NEG;
         v_next = quo + ONE;
      end else if (rem == ONE) begin
         code   = BT_POS;
         v_next = quo;
      end else begin
         code   = BT_ZERO;
         v_next = quo;
      end
   end
endmodule

// File: rtl/bt_digit_slot.sv
module bt_digit_slot
   import bt_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       clr,
   input  logic       wr,
   input  bt_digit_e  code,
   output logic [1:0] q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   q <= BT_ZERO;
      else if (clr) q <= BT_ZERO;
      else if (wr)  q <= code;
   end

   assert_no_reserved_code_R1: assert property (@(posedge clk) disable iff (!rst_n)
      q != 2'b11);
endmodule

// File: rtl/bt_converter.sv
module bt_converter
   import bt_pkg::*;
#(
   parameter int IN_W = 16,
   parameter int NDIG = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [IN_W-1:0]   din,
   output logic              busy,
   output logic              done,
   output logic              overflow,
   output logic [2*NDIG-1:0] digits
);
   localparam longint LIM  = bt_limit(NDIG);
   localparam int     VW   = bt_bits_for(LIM) + 2;
   localparam int     CW   = (NDIG > 1) ? $clog2(NDIG) : 1;
   localparam logic [CW-1:0] LAST = CW'(NDIG - 1);

   generate
      if (NDIG < 2 || NDIG > 20) begin : g_bad_ndig
         $error("bt_converter: NDIG must lie in 2..20");
      end
      if (IN_W < 2) begin : g_bad_inw
         $error("bt_converter: IN_W must be at least 2");
      end
   endgenerate

   logic                 accept;
   logic                 over_w;
   logic signed [VW-1:0] init_val;
   logic signed [VW-1:0] run_q;
   logic signed [VW-1:0] run_next;
   bt_digit_e            step_code;
   logic [CW-1:0]        cnt_q;

   assign accept = start && !busy;

   bt_range_check #(.IN_W(IN_W), .VW(VW), .LIM(LIM)) u_range (
      .din       (din),
      .over      (over_w),
      .start_val (init_val)
   );

   bt_digit_step #(.VW(VW)) u_step (
      .v      (run_q),
      .code   (step_code),
      .v_next (run_next)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy     <= 1'b0;
         done     <= 1'b0;
         overflow <= 1'b0;
         cnt_q    <= '0;
         run_q    <= '0;
      end else if (accept) begin
         busy     <= 1'b1;
         done     <= 1'b0;
         overflow <= over_w;
         cnt_q    <= '0;
         run_q    <= init_val;
      end else if (busy) begin
         run_q <= run_next;
         cnt_q <= cnt_q + 1'b1;
         if (cnt_q == LAST) begin
            busy <= 1'b0;
            done <= 1'b1;
         end
      end else begin
         done <= 1'b0;
      end
   end

   for (genvar i = 0; i < NDIG; i++) begin : g_slot
      bt_digit_slot u_slot (
         .clk   (clk),
         .rst_n (rst_n),
         .clr   (accept),
         .wr    (busy && (cnt_q == CW'(i))),
         .code  (step_code),
         .q     (digits[2*i +: 2])
      );
   end

   assert_accept_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> (busy && cnt_q == '0));
   assert_done_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   assert_done_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);
   assert_busy_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start) |=> (busy || done));
   assert_ovf_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
      overflow |-> (digits == '0));
endmodule

// File: tb/bt_converter_bench.sv
module bt_converter_bench;
   localparam int CLK_PERIOD = 10;
   localparam int IN_W = 16;
   localparam int NDIG = 8;
   localparam int NV   = 13;

   localparam int    VALS [NV] = '{21, 296, -24, -137, 0, 1, -1, 2, 5, 13, 4, 3280, -3280};
   localparam string EXPS [NV] = '{"1T10", "11T00T", "T010", "T110T1", "0", "1", "T",
                                   "1T", "1TT", "111", "11", "11111111", "TTTTTTTT"};

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              start = 1'b0;
   logic [IN_W-1:0]   din = '0;
   logic              busy, done, overflow;
   logic [2*NDIG-1:0] digits;

   int  n_checks = 0;
   int  n_fail   = 0;
   bit  finished = 1'b0;
   logic [2*NDIG-1:0] res_a, res_b;

   always #(CLK_PERIOD/2) clk = ~clk;

   bt_converter #(.IN_W(IN_W), .NDIG(NDIG)) u_bt_converter (
      .clk(clk), .rst_n(rst_n), .start(start), .din(din),
      .busy(busy), .done(done), .overflow(overflow), .digits(digits)
   );

   task automatic check(input bit ok, input string req, input longint act, input longint exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [2*NDIG-1:0] from_text(input string s);
      logic [2*NDIG-1:0] r;
      int L;
      r = '0;
      L = s.len();
      for (int k = 0; k < L; k++) begin
         case (s[L-1-k])
            "1":     r[2*k +: 2] = 2'b01;
            "T":     r[2*k +: 2] = 2'b10;
            default: r[2*k +: 2] = 2'b00;
         endcase
      end
      return r;
   endfunction

   function automatic longint weigh(input logic [2*NDIG-1:0] d);
      longint acc, w;
      acc = 0; w = 1;
      for (int k = 0; k < NDIG; k++) begin
         if (d[2*k +: 2] == 2'b01) acc = acc + w;
         else if (d[2*k +: 2] == 2'b10) acc = acc - w;
         w = w * 3;
      end
      return acc;
   endfunction

   function automatic bit has_reserved(input logic [2*NDIG-1:0] d);
      for (int k = 0; k < NDIG; k++) if (d[2*k +: 2] == 2'b11) return 1'b1;
      return 1'b0;
   endfunction

   function automatic logic [2*NDIG-1:0] swap_sign(input logic [2*NDIG-1:0] d);
      logic [2*NDIG-1:0] r;
      for (int k = 0; k < NDIG; k++) r[2*k +: 2] = {d[2*k], d[2*k+1]};
      return r;
   endfunction

   // Starts a conversion at an idle block; optional stray strobe at busy cycle 3.
   task automatic convert(input int v, input bit stray, input int stray_v,
                          output logic [2*NDIG-1:0] res);
      @(negedge clk);
      din = IN_W'(v); start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      check(busy == 1'b1, "R3 busy after accept", busy, 1);
      for (int c = 1; c <= NDIG - 1; c++) begin
         if (stray && c == 3) begin din = IN_W'(stray_v); start = 1'b1; end
         @(negedge clk);
         start = 1'b0;
         if (done) check(1'b0, "R4 early done", c, NDIG);
      end
      @(negedge clk);
      check(done == 1'b1 && busy == 1'b0, "R4 done at final digit", {done, busy}, 2'b10);
      res = digits;
      @(negedge clk);
      check(done == 1'b0, "R4 done one cycle", done, 0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_checks++; n_fail++;
         $display("FAIL watchdog expired");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R9 reset state
      check(busy == 0 && done == 0 && overflow == 0 && digits == '0, "R9 reset state",
            {busy, done, overflow}, 0);
      rst_n = 1'b1;

      for (int t = 0; t < NV; t++) begin
         convert(VALS[t], 1'b0, 0, res_a);
         check(res_a == from_text(EXPS[t]), "R2 digit word", res_a, from_text(EXPS[t]));
         check(weigh(res_a) == longint'(VALS[t]), "R2 weighted sum", weigh(res_a), VALS[t]);
         check(!has_reserved(res_a), "R1 no reserved code", res_a, 0);
         check(overflow == 1'b0, "R6 in range no overflow", overflow, 0);
      end

      // R8 negation symmetry
      convert(137, 1'b0, 0, res_a);
      convert(-137, 1'b0, 0, res_b);
      check(res_b == swap_sign(res_a), "R8 negation swap", res_b, swap_sign(res_a));
      convert(1000, 1'b0, 0, res_a);
      convert(-1000, 1'b0, 0, res_b);
      check(res_b == swap_sign(res_a), "R8 negation swap 1000", res_b, swap_sign(res_a));

      // R5 stray start ignored
      convert(21, 1'b1, 296, res_a);
      check(res_a == from_text("1T10"), "R5 stray start ignored", res_a, from_text("1T10"));

      // R6 overflow on both sides
      convert(3281, 1'b0, 0, res_a);
      check(overflow == 1 && res_a == '0, "R6 overflow +3281", {overflow, res_a}, 17'h10000);
      convert(-3281, 1'b0, 0, res_a);
      check(overflow == 1 && res_a == '0, "R6 overflow -3281", {overflow, res_a}, 17'h10000);
      convert(-32768, 1'b0, 0, res_a);
      check(overflow == 1 && res_a == '0, "R6 overflow min", {overflow, res_a}, 17'h10000);

      // R7 hold then clear
      repeat (5) @(negedge clk);
      check(overflow == 1 && digits == '0, "R7 overflow held", overflow, 1);
      convert(296, 1'b0, 0, res_a);
      check(overflow == 0 && res_a == from_text("11T00T"), "R7 cleared by start",
            {overflow, res_a}, from_text("11T00T"));
      repeat (4) @(negedge clk);
      check(digits == from_text("11T00T"), "R7 digits held", digits, from_text("11T00T"));

      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end
endmodule